// File: doc/BRIEF.md
# Layer-2 Forwarding Table Read Engine

This block fetches one entry of a switch's layer-2 forwarding table on command. Software writes a control word that carries a go bit, a table selector and an entry index. It then polls the go bit, which the hardware holds high while the access runs and drops once the result is in place. Two tables sit behind the engine. The first is a hashed table organised as buckets of four entries, indexed by the hash shifted left by two plus the slot within the bucket. The second is a small overflow CAM.

Each entry is three 32-bit raw words. The engine presents them on three data outputs and also presents the fields unpacked: the 48-bit station address, the VLAN ID, the reverse VLAN ID, the port number, the static flag and the valid flag. The address straddles two words, with its fourth byte split across the word boundary. A fill port writes entries into either table so that a surrounding model or bench can set their contents.

Top module: `l2_entry_reader`

## Requirements
- R1: After reset the go bit reads 0, all three data words read zero, and every unpacked field, including the valid flag, reads zero.
- R2: A write with control bit 16 set, made while idle, starts an access. Bit 16 of the control readback is 1 after the write edge and after the next edge. It is 0 after the second edge, and in that same cycle the data words and fields show the new entry. Readback bits [14:0] return the stored selector and index, and bit 15 is stored and read back unchanged.
- R3: A control write while the go bit reads 1 is ignored: the access in flight completes with its original selector and index.
- R4: The selector occupies control bits [14:13]. Value 0 reads the hashed table and value 1 reads the CAM. The index occupies bits [12:0]. For the hashed table the index is (hash << 2) | slot, where slot 0..3 is the place in the bucket and the hash has HASH_W bits.
- R5: Word 0 unpacks as follows: VLAN ID = bits [11:0], port = bits [16:12], static = bit 19. The entry is valid when any of bits [31:17] is 1, and invalid when all of them are 0.
- R6: The address is {word1[27:0], word2[31:12]}, most significant byte first, so its fourth byte is word1[3:0] followed by word2[31:28]. The reverse VLAN ID is word2[11:0].
- R7: The access returns an all-zero entry, which reports invalid, in three cases: a CAM index at or above CAM_DEPTH (64), a hashed index at or above 4<<HASH_W, and a selector of 2 or 3.
- R8: Data words and fields change only at the completion of an access. A control write with bit 16 clear starts nothing. Neither such a write nor a fill changes the outputs.
- R9: The fill port writes the three words into the CAM when the CAM select is 1, or into the hashed table when it is 0, at the index given. A later access to that index returns exactly those words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdWrEn | input | 1 | Control word write strobe |
| cmdWrData | input | 17 | Control word: [16] go, [15] spare, [14:13] selector, [12:0] index |
| ctrlRd | output | 17 | Control readback, [16] = access in progress |
| fillEn | input | 1 | Table fill strobe |
| fillCam | input | 1 | Fill target: 1 = CAM, 0 = hashed table |
| fillIdx | input | 13 | Fill index |
| fillWord0 | input | 32 | Fill entry word 0 |
| fillWord1 | input | 32 | Fill entry word 1 |
| fillWord2 | input | 32 | Fill entry word 2 |
| dataWord0 | output | 32 | Raw entry word 0 |
| dataWord1 | output | 32 | Raw entry word 1 |
| dataWord2 | output | 32 | Raw entry word 2 |
| macAddr | output | 48 | Unpacked station address |
| vlanId | output | 12 | Unpacked VLAN ID |
| revVlanId | output | 12 | Unpacked reverse VLAN ID |
| portNum | output | 5 | Unpacked port number |
| isStatic | output | 1 | Unpacked static flag |
| isValid | output | 1 | Entry valid flag |

## Verification
A control state machine stuck or skipping a state shows up directly at bit 16 of the readback: the go bit stays high too long, or drops one edge early, within two cycles of the write. A selector or index latched wrongly, or overwritten by a write made while busy, shows as data words that differ from the preloaded entry at the completion cycle. A mis-sliced unpack shows as an address, VLAN or flag field that disagrees with the raw words presented in the same cycle. Out-of-range and reserved-selector reads are aimed so that a missing range guard returns stale or wrapped data instead of zero.

// File: rtl/l2rd_pkg.sv
package l2rd_pkg;
  localparam int CTRL_W   = 17;
  localparam int GO_BIT   = 16;
  localparam int SPARE_BIT = 15;
  localparam int SEL_LSB  = 13;
  localparam int IDX_W    = 13;

  typedef enum logic [1:0] {
    SEL_HASH = 2'd0,
    SEL_CAM  = 2'd1
  } tableSel_e;

  typedef struct packed {
    logic [31:0] w2;
    logic [31:0] w1;
    logic [31:0] w0;
  } rawEntry_t;

  typedef struct packed {
    logic latchCmd;
    logic fetch;
    logic load;
  } strobes_t;
endpackage

// File: rtl/l2rd_table.sv
module l2rd_table
  import l2rd_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  rawEntry_t        wrData,
  input  logic [AW-1:0]    rdIdx,
  output rawEntry_t        rdData
);
  rawEntry_t mem [DEPTH];

  logic wrInRange;
  assign wrInRange = int'(wrIdx) < DEPTH;

  always_ff @(posedge clk) begin
    if (wrEn && wrInRange) mem[wrIdx[AW-1:0]] <= wrData;
  end

  assign rdData = mem[rdIdx];
endmodule

// File: rtl/l2rd_ctrl.sv
module l2rd_ctrl
  import l2rd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdWrEn,
  input  logic     goBit,
  output strobes_t strobe,
  output logic     busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOAD} state_e;
  state_e state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdWrEn && goBit) begin
          strobe.latchCmd = 1'b1;
          nextState       = ST_FETCH;
        end
      end
      ST_FETCH: begin
        strobe.fetch = 1'b1;
        nextState    = ST_LOAD;
      end
      ST_LOAD: begin
        strobe.load = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);

  // R2: busy lasts exactly two cycles
  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);
  p_busy_ends_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |=> !busy);
  // R3: no new command accepted while busy
  p_no_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrEn && goBit) |=> (state != ST_FETCH));
endmodule

// File: rtl/l2rd_datapath.sv
module l2rd_datapath
  import l2rd_pkg::*;
#(
  parameter int HASH_W    = 4,
  parameter int CAM_DEPTH = 64,
  localparam int HASH_DEPTH = 4 << HASH_W,
  localparam int HASH_AW = $clog2(HASH_DEPTH),
  localparam int CAM_AW  = (CAM_DEPTH > 1) ? $clog2(CAM_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobe,
  input  logic              busy,
  input  logic              cmdWrEn,
  input  logic [CTRL_W-1:0] cmdWrData,
  output logic [CTRL_W-1:0] ctrlRd,
  input  logic              fillEn,
  input  logic              fillCam,
  input  logic [IDX_W-1:0]  fillIdx,
  input  rawEntry_t         fillData,
  output rawEntry_t         dataOut,
  output logic [47:0]       macAddr,
  output logic [11:0]       vlanId,
  output logic [11:0]       revVlanId,
  output logic [4:0]        portNum,
  output logic              isStatic,
  output logic              isValid
);
  logic [1:0]       cmdSel;
  logic [IDX_W-1:0] cmdIdx;
  logic             cmdSpare;
  rawEntry_t        hashRd, camRd, selEntry, fetchEntry;
  logic             selZero, fetchZero;

  // two table instances differ only by depth and fill target
  generate
    for (genvar t = 0; t < 2; t++) begin : g_tbl
      localparam int D = (t == 0) ? HASH_DEPTH : CAM_DEPTH;
      localparam int A = (D > 1) ? $clog2(D) : 1;
      rawEntry_t rd;
      l2rd_table #(.DEPTH(D)) u_tbl (
        .clk    (clk),
        .wrEn   (fillEn && (fillCam == (t == 1))),
        .wrIdx  (fillIdx),
        .wrData (fillData),
        .rdIdx  (cmdIdx[A-1:0]),
        .rdData (rd)
      );
    end
  endgenerate

  assign hashRd = g_tbl[0].rd;
  assign camRd  = g_tbl[1].rd;

  always_comb begin
    selEntry = '0;
    selZero  = 1'b1;
    unique case (cmdSel)
      SEL_HASH: if (int'(cmdIdx) < HASH_DEPTH) begin
        selEntry = hashRd;
        selZero  = 1'b0;
      end
      SEL_CAM: if (int'(cmdIdx) < CAM_DEPTH) begin
        selEntry = camRd;
        selZero  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSel     <= '0;
      cmdIdx     <= '0;
      cmdSpare   <= 1'b0;
      fetchEntry <= '0;
      fetchZero  <= 1'b0;
      dataOut    <= '0;
      macAddr    <= '0;
      vlanId     <= '0;
      revVlanId  <= '0;
      portNum    <= '0;
      isStatic   <= 1'b0;
      isValid    <= 1'b0;
    end else begin
      if (strobe.latchCmd) begin
        cmdSel   <= cmdWrData[SEL_LSB +: 2];
        cmdIdx   <= cmdWrData[IDX_W-1:0];
        cmdSpare <= cmdWrData[SPARE_BIT];
      end
      if (strobe.fetch) begin
        fetchEntry <= selEntry;
        fetchZero  <= selZero;
      end
      if (strobe.load) begin
        dataOut   <= fetchEntry;
        macAddr   <= {fetchEntry.w1[27:0], fetchEntry.w2[31:12]};
        vlanId    <= fetchEntry.w0[11:0];
        revVlanId <= fetchEntry.w2[11:0];
        portNum   <= fetchEntry.w0[16:12];
        isStatic  <= fetchEntry.w0[19];
        isValid   <= |fetchEntry.w0[31:17];
      end
    end
  end

  assign ctrlRd = {busy, cmdSpare, cmdSel, cmdIdx};

  // R3: command fields frozen while a write arrives during an access
  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrEn) |=> ($stable(cmdIdx) && $stable(cmdSel)));
  // R7: out-of-range or reserved selector yields a zero, invalid entry
  p_oor_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && fetchZero) |=> (dataOut == '0 && !isValid));
  // R8: outputs move only on completion
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(dataOut) && $stable(macAddr) && $stable(isValid)));
  // R5: valid flag agrees with the presented word 0
  p_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load) |-> (isValid == (dataOut.w0[31:17] != '0)));
endmodule

// File: rtl/l2_entry_reader.sv
module l2_entry_reader
  import l2rd_pkg::*;
#(
  parameter int HASH_W    = 4,
  parameter int CAM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [CTRL_W-1:0] cmdWrData,
  output logic [CTRL_W-1:0] ctrlRd,
  input  logic              fillEn,
  input  logic              fillCam,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [31:0]       fillWord0,
  input  logic [31:0]       fillWord1,
  input  logic [31:0]       fillWord2,
  output logic [31:0]       dataWord0,
  output logic [31:0]       dataWord1,
  output logic [31:0]       dataWord2,
  output logic [47:0]       macAddr,
  output logic [11:0]       vlanId,
  output logic [11:0]       revVlanId,
  output logic [4:0]        portNum,
  output logic              isStatic,
  output logic              isValid
);
  strobes_t  strobe;
  logic      busy;
  rawEntry_t fillData, dataOut;

  assign fillData = '{w2: fillWord2, w1: fillWord1, w0: fillWord0};

  l2rd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWrEn (cmdWrEn),
    .goBit   (cmdWrData[GO_BIT]),
    .strobe  (strobe),
    .busy    (busy)
  );

  l2rd_datapath #(.HASH_W(HASH_W), .CAM_DEPTH(CAM_DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busy      (busy),
    .cmdWrEn   (cmdWrEn),
    .cmdWrData (cmdWrData),
    .ctrlRd    (ctrlRd),
    .fillEn    (fillEn),
    .fillCam   (fillCam),
    .fillIdx   (fillIdx),
    .fillData  (fillData),
    .dataOut   (dataOut),
    .macAddr   (macAddr),
    .vlanId    (vlanId),
    .revVlanId (revVlanId),
    .portNum   (portNum),
    .isStatic  (isStatic),
    .isValid   (isValid)
  );

  assign dataWord0 = dataOut.w0;
  assign dataWord1 = dataOut.w1;
  assign dataWord2 = dataOut.w2;
endmodule

// File: tb/sim_l2_entry_reader.sv
`timescale 1ns/1ps
module sim_l2_entry_reader;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [16:0] cmdWrData = '0;
  logic [16:0] ctrlRd;
  logic        fillEn = 1'b0, fillCam = 1'b0;
  logic [12:0] fillIdx = '0;
  logic [31:0] fillWord0 = '0, fillWord1 = '0, fillWord2 = '0;
  logic [31:0] dataWord0, dataWord1, dataWord2;
  logic [47:0] macAddr;
  logic [11:0] vlanId, revVlanId;
  logic [4:0]  portNum;
  logic        isStatic, isValid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [95:0] modelHash [DEPTH];
  logic [95:0] modelCam  [DEPTH];

  always #2 clk = ~clk;

  l2_entry_reader u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", 96'(cycles), 96'd100000);
      finishRun();
    end
  end

  function automatic logic [95:0] pattern(input int idx, input bit cam);
    logic [31:0] a;
    a = 32'h9E3779B9 * (idx + 1) ^ (cam ? 32'h5A5AA5A5 : 32'h0);
    return {~a ^ 32'(idx << 4), a * 7 + 3, a | 32'h0002_0000};
  endfunction

  function automatic logic [95:0] refEntry(input logic [1:0] sel, input logic [12:0] idx);
    if (sel == 2'd0 && idx < DEPTH) return modelHash[idx];
    if (sel == 2'd1 && idx < DEPTH) return modelCam[idx];
    return '0;
  endfunction

  task automatic fill(input bit cam, input int idx, input logic [95:0] e);
    @(negedge clk);
    fillEn = 1'b1; fillCam = cam; fillIdx = 13'(idx);
    {fillWord2, fillWord1, fillWord0} = e;
    if (cam) modelCam[idx] = e; else modelHash[idx] = e;
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  // check data words and unpacked fields against an expected raw entry
  task automatic chkEntry(input logic [95:0] e);
    logic [31:0] w0, w1, w2;
    {w2, w1, w0} = e;
    chk({dataWord2, dataWord1, dataWord0} == e, "R4 R9 raw words", {dataWord2, dataWord1, dataWord0}, e);
    chk(vlanId == w0[11:0], "R5 vlan", 96'(vlanId), 96'(w0[11:0]));
    chk(portNum == w0[16:12], "R5 port", 96'(portNum), 96'(w0[16:12]));
    chk(isStatic == w0[19], "R5 static", 96'(isStatic), 96'(w0[19]));
    chk(isValid == (w0[31:17] != 0), "R5 valid", 96'(isValid), 96'(w0[31:17] != 0));
    chk(macAddr == {w1[27:0], w2[31:12]}, "R6 mac", 96'(macAddr), 96'({w1[27:0], w2[31:12]}));
    chk(revVlanId == w2[11:0], "R6 rvid", 96'(revVlanId), 96'(w2[11:0]));
  endtask

  task automatic runCmd(input logic [1:0] sel, input logic [12:0] idx);
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWrData = {1'b1, 1'b0, sel, idx};
    @(negedge clk);
    cmdWrEn = 1'b0;
    chk(ctrlRd[16] == 1'b1, "R2 busy first cycle", 96'(ctrlRd), 96'h1_0000);
    chk(ctrlRd[14:0] == {sel, idx}, "R2 readback fields", 96'(ctrlRd[14:0]), 96'({sel, idx}));
    @(negedge clk);
    chk(ctrlRd[16] == 1'b1, "R2 busy second cycle", 96'(ctrlRd[16]), 96'd1);
    @(negedge clk);
    chk(ctrlRd[16] == 1'b0, "R2 busy cleared", 96'(ctrlRd[16]), 96'd0);
    chkEntry(refEntry(sel, idx));
  endtask

  // {selector, index}
  localparam int NV = 13;
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 13'd0},  {2'd0, 13'd7},  {2'd0, 13'd14}, {2'd0, 13'd9},
    {2'd0, 13'd63}, {2'd1, 13'd0},  {2'd1, 13'd5},  {2'd1, 13'd63},
    {2'd1, 13'd64}, {2'd1, 13'd8191}, {2'd0, 13'd64}, {2'd2, 13'd3},
    {2'd3, 13'd1}
  };

  initial begin
    logic [95:0] held;
    #1;
    // R1: reset state
    chk(ctrlRd[16] == 1'b0, "R1 busy", 96'(ctrlRd), 96'd0);
    chk({dataWord2, dataWord1, dataWord0} == 0, "R1 words", {dataWord2, dataWord1, dataWord0}, 96'd0);
    chk(!isValid && macAddr == 0 && vlanId == 0, "R1 fields", 96'(macAddr), 96'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: fill both tables
    for (int i = 0; i < DEPTH; i++) fill(1'b0, i, pattern(i, 1'b0));
    for (int i = 0; i < DEPTH; i++) fill(1'b1, i, pattern(i, 1'b1));
    // R5: invalid entry with valid bits clear, bucket 2 slot 1
    fill(1'b0, 9, {32'hFFFF_F123, 32'h0ABC_DEF0, 32'h0001_FFFF});
    // R6 R4: hash 3 slot 2 -> index 14, address 01:23:45:67:89:AB
    fill(1'b0, (3 << 2) | 2, {32'h789A_BABC, 32'h0012_3456, 32'h0009_1123});

    for (int v = 0; v < NV; v++) runCmd(VEC[v][14:13], VEC[v][12:0]);

    // R6: literal address split across words
    runCmd(2'd0, 13'd14);
    chk(macAddr == 48'h0123_4567_89AB, "R6 literal mac", 96'(macAddr), 96'h0123_4567_89AB);
    chk(portNum == 5'd17 && isStatic && vlanId == 12'h123, "R5 literal fields", 96'({portNum, isStatic, vlanId}), 96'({5'd17, 1'b1, 12'h123}));
    chk(revVlanId == 12'hABC, "R6 literal rvid", 96'(revVlanId), 96'hABC);

    // R3: write while busy is ignored
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWrData = {1'b1, 1'b0, 2'd1, 13'd5};
    @(negedge clk);
    cmdWrData = {1'b1, 1'b0, 2'd0, 13'd7};
    @(negedge clk);
    cmdWrEn = 1'b0;
    chk(ctrlRd[14:0] == {2'd1, 13'd5}, "R3 fields kept", 96'(ctrlRd[14:0]), 96'({2'd1, 13'd5}));
    @(negedge clk);
    chk(ctrlRd[16] == 1'b0, "R3 completes on time", 96'(ctrlRd[16]), 96'd0);
    chk({dataWord2, dataWord1, dataWord0} == modelCam[5], "R3 original entry", {dataWord2, dataWord1, dataWord0}, modelCam[5]);
    repeat (3) @(negedge clk);
    chk(ctrlRd[16] == 1'b0 && {dataWord2, dataWord1, dataWord0} == modelCam[5], "R3 no late start", {dataWord2, dataWord1, dataWord0}, modelCam[5]);

    // R8: write without go bit and a fill leave outputs alone
    held = {dataWord2, dataWord1, dataWord0};
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWrData = {1'b0, 1'b1, 2'd0, 13'd0};
    @(negedge clk);
    cmdWrEn = 1'b0;
    chk(ctrlRd[16] == 1'b0, "R8 no start", 96'(ctrlRd[16]), 96'd0);
    fill(1'b1, 5, 96'h1111_2222_3333_4444_5555_6666);
    repeat (3) @(negedge clk);
    chk({dataWord2, dataWord1, dataWord0} == held, "R8 outputs held", {dataWord2, dataWord1, dataWord0}, held);

    // R9: refilled CAM entry now returned; R2 spare bit round trip
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWrData = {1'b1, 1'b1, 2'd1, 13'd5};
    @(negedge clk);
    cmdWrEn = 1'b0;
    chk(ctrlRd[15] == 1'b1, "R2 spare bit", 96'(ctrlRd[15]), 96'd1);
    repeat (2) @(negedge clk);
    chkEntry(modelCam[5]);

    finishRun();
  end
endmodule